// File: doc/BRIEF.md
# Serial Byte Aligner with Sync Search

This block turns an unbroken serial bit stream, clocked by its own bit clock, into aligned bytes. Bits enter an 8-bit shift register most significant bit first. While hunting, every bit position is compared against a programmable sync pattern. On the first match, the block locks. A 3-bit bit counter then marks each 8-bit boundary, and a slot counter tracks a frame: `PERIOD_BYTES` payload bytes followed by one slot where the sync pattern is expected again.

The lock is not permanent. A resync request drops it and restarts the search. So does a run of `MISS_LIMIT` consecutive sync slots that fail to match. Each payload byte is passed into an unrelated system clock domain. The crossing uses a holding register and a toggle flag, a two-flop synchroniser and an edge detector. The system domain sees every byte as a one-cycle valid pulse.

The lock controller has two states. HUNT is the search state, and its single exit, the "sync match" transition, goes to LOCKED. LOCKED leaves through "resync request" or "miss limit reached", both back to HUNT. Every other cycle is a self-loop.

Top module: `sba_aligner`

## Requirements
- R1: A synchronous active-high reset in each domain clears that domain. After `bit_rst`, `sync_found` is 0. After `sys_rst`, `byte_valid` is 0 and `byte_out` is 0x00.
- R2: Bits are shifted in MSB first. In HUNT, `sync_found` rises at the bit-clock edge where the last 8 received bits equal `SYNC_PAT` (default 0x47). The earliest of the 8 bits is the MSB. Until then `sync_found` stays 0.
- R3: The 8 bits after the matching sync byte form the first payload byte. After that, each group of 8 bits is one byte. A frame is `PERIOD_BYTES` payload bytes and then one sync slot. Sync-slot bytes are never delivered.
- R4: While locked, a payload byte equal to `SYNC_PAT` causes no realignment. It is delivered like any other byte, and `sync_found` stays 1.
- R5: A sync slot that matches `SYNC_PAT` clears the miss count. A sync slot that differs from `SYNC_PAT` adds one to the miss count. When the count reaches `MISS_LIMIT`, `sync_found` falls at the edge that completes that slot. Fewer consecutive misses leave the lock in place.
- R6: `resync` high at a bit-clock edge forces HUNT at that edge, so `sync_found` is 0 afterwards. This takes priority over a pattern match in the same cycle, and no byte completing in that cycle is delivered.
- R7: Each payload byte appears on `byte_out` with `byte_valid` high for exactly one system cycle. Bytes arrive in stream order, with none lost and none duplicated.
- R8: While `byte_valid` is low, `byte_out` keeps the last delivered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock |
| bit_rst | input | 1 | Synchronous active-high reset, bit domain |
| ser_in | input | 1 | Serial data, one bit per bit_clk |
| resync | input | 1 | Drops lock and restarts the search (bit domain) |
| sync_found | output | 1 | 1 while locked (bit domain) |
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| byte_out | output | 8 | Last delivered payload byte (system domain) |
| byte_valid | output | 1 | One-cycle pulse per new byte (system domain) |

## Verification
The bench builds the block with `PERIOD_BYTES` = 3 and `MISS_LIMIT` = 2, and keeps the default pattern 0x47. With frames of four bytes, many sync slots occur in a short run. This makes the sequences that matter reachable within a few hundred bits: a single miss that keeps the lock, a good sync that clears the count, and two consecutive misses that drop the lock. The bit clock runs at a slower unrelated period than the 250 MHz system clock, so each toggle crosses well within one byte time.

// File: rtl/sba_pkg.sv
package sba_pkg;
    typedef enum logic {
        ST_HUNT   = 1'b0,
        ST_LOCKED = 1'b1
    } sba_state_e;
endpackage

// File: rtl/sba_shift.sv
// Serial-in shift register, MSB first; exposes the value after the current bit.
module sba_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         din,
    output logic [W-1:0] sr_next
);
    logic [W-1:0] sr_q;

    assign sr_next = {sr_q[W-2:0], din};

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= sr_next;
    end
endmodule

// File: rtl/sba_lock_fsm.sv
// Hunt/lock controller: bit counter, frame slot counter, miss counter.
module sba_lock_fsm
    import sba_pkg::*;
#(
    parameter int           W            = 8,
    parameter logic [W-1:0] SYNC_PAT     = 8'h47,
    parameter int           PERIOD_BYTES = 187,
    parameter int           MISS_LIMIT   = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         resync,
    input  logic [W-1:0] sr_next,
    output logic         locked,
    output logic         byte_done,
    output logic [W-1:0] byte_data
);
    localparam int CNT_W  = (W > 2) ? $clog2(W) : 1;
    localparam int SLOT_W = $clog2(PERIOD_BYTES + 1);
    localparam int MISS_W = (MISS_LIMIT > 1) ? $clog2(MISS_LIMIT + 1) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(W - 1);
    localparam logic [SLOT_W-1:0] SLOT_SYNC = SLOT_W'(PERIOD_BYTES);
    localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(MISS_LIMIT - 1);

    sba_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [MISS_W-1:0] miss_q, miss_d;

    logic at_edge, sync_slot, pat_hit;
    assign at_edge   = (cnt_q == CNT_LAST);
    assign sync_slot = (slot_q == SLOT_SYNC);
    assign pat_hit   = (sr_next == SYNC_PAT);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT;
            cnt_q   <= '0;
            slot_q  <= '0;
            miss_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            slot_q  <= slot_d;
            miss_q  <= miss_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        slot_d  = slot_q;
        miss_d  = miss_q;
        if (resync) begin
            // resync request
            state_d = ST_HUNT;
            cnt_d   = '0;
            slot_d  = '0;
            miss_d  = '0;
        end else begin
            unique case (state_q)
                ST_HUNT: begin
                    if (pat_hit) begin
                        // sync match
                        state_d = ST_LOCKED;
                        cnt_d   = '0;
                        slot_d  = '0;
                        miss_d  = '0;
                    end
                end
                ST_LOCKED: begin
                    cnt_d = at_edge ? '0 : cnt_q + 1'b1;
                    if (at_edge) begin
                        if (sync_slot) begin
                            slot_d = '0;
                            if (pat_hit) begin
                                miss_d = '0;
                            end else if (miss_q == MISS_LAST) begin
                                // miss limit reached
                                state_d = ST_HUNT;
                                miss_d  = '0;
                            end else begin
                                miss_d = miss_q + 1'b1;
                            end
                        end else begin
                            slot_d = slot_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        locked    = (state_q == ST_LOCKED);
        byte_done = (state_q == ST_LOCKED) && !resync && at_edge && !sync_slot;
        byte_data = sr_next;
    end
endmodule

// File: rtl/sba_cdc.sv
// Holding register plus toggle in the bit domain, toggle synchroniser and
// edge detector in the system domain.
module sba_cdc #(
    parameter int W = 8
) (
    input  logic         bit_clk,
    input  logic         bit_rst,
    input  logic         cap,
    input  logic [W-1:0] cap_data,
    input  logic         sys_clk,
    input  logic         sys_rst,
    output logic [W-1:0] byte_out,
    output logic         byte_valid
);
    logic [W-1:0] hold_q;
    logic         tog_q;
    logic         sy1_q, sy2_q, sy3_q;
    logic         edge_seen;

    always_ff @(posedge bit_clk) begin
        if (bit_rst) begin
            hold_q <= '0;
            tog_q  <= 1'b0;
        end else if (cap) begin
            hold_q <= cap_data;
            tog_q  <= ~tog_q;
        end
    end

    assign edge_seen = sy2_q ^ sy3_q;

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            sy1_q      <= 1'b0;
            sy2_q      <= 1'b0;
            sy3_q      <= 1'b0;
            byte_valid <= 1'b0;
            byte_out   <= '0;
        end else begin
            sy1_q      <= tog_q;
            sy2_q      <= sy1_q;
            sy3_q      <= sy2_q;
            byte_valid <= edge_seen;
            if (edge_seen) byte_out <= hold_q;
        end
    end
endmodule

// File: rtl/sba_aligner.sv
module sba_aligner #(
    parameter int         PERIOD_BYTES = 187,
    parameter int         MISS_LIMIT   = 3,
    parameter logic [7:0] SYNC_PAT     = 8'h47
) (
    input  logic       bit_clk,
    input  logic       bit_rst,
    input  logic       ser_in,
    input  logic       resync,
    output logic       sync_found,
    input  logic       sys_clk,
    input  logic       sys_rst,
    output logic [7:0] byte_out,
    output logic       byte_valid
);
    localparam int W = 8;

    logic [W-1:0] sr_next;
    logic         byte_done;
    logic [W-1:0] byte_data;

    sba_shift #(.W(W)) u_shift (
        .clk     (bit_clk),
        .rst     (bit_rst),
        .din     (ser_in),
        .sr_next (sr_next)
    );

    sba_lock_fsm #(
        .W            (W),
        .SYNC_PAT     (SYNC_PAT),
        .PERIOD_BYTES (PERIOD_BYTES),
        .MISS_LIMIT   (MISS_LIMIT)
    ) u_fsm (
        .clk       (bit_clk),
        .rst       (bit_rst),
        .resync    (resync),
        .sr_next   (sr_next),
        .locked    (sync_found),
        .byte_done (byte_done),
        .byte_data (byte_data)
    );

    sba_cdc #(.W(W)) u_cdc (
        .bit_clk    (bit_clk),
        .bit_rst    (bit_rst),
        .cap        (byte_done),
        .cap_data   (byte_data),
        .sys_clk    (sys_clk),
        .sys_rst    (sys_rst),
        .byte_out   (byte_out),
        .byte_valid (byte_valid)
    );
endmodule

// File: rtl/sba_aligner_chk.sv
module sba_aligner_chk (
    input logic       bit_clk,
    input logic       bit_rst,
    input logic       resync,
    input logic       sync_found,
    input logic       byte_done,
    input logic       sys_clk,
    input logic       sys_rst,
    input logic [7:0] byte_out,
    input logic       byte_valid
);
    AST_RESET_UNLOCKS: assert property (@(posedge bit_clk) bit_rst |=> !sync_found); // R1
    AST_RESYNC_DROPS: assert property (@(posedge bit_clk) disable iff (bit_rst) resync |=> !sync_found); // R6
    AST_NO_LOCK_ON_RESYNC: assert property (@(posedge bit_clk) disable iff (bit_rst) $rose(sync_found) |-> !$past(resync)); // R6
    AST_STROBE_WHILE_LOCKED: assert property (@(posedge bit_clk) disable iff (bit_rst) byte_done |-> sync_found); // R3
    AST_VALID_ONE_CYCLE: assert property (@(posedge sys_clk) disable iff (sys_rst) byte_valid |=> !byte_valid); // R7
    AST_OUT_HELD: assert property (@(posedge sys_clk) disable iff (sys_rst) !byte_valid |-> $stable(byte_out)); // R8
endmodule

bind sba_aligner sba_aligner_chk u_chk (
    .bit_clk    (bit_clk),
    .bit_rst    (bit_rst),
    .resync     (resync),
    .sync_found (sync_found),
    .byte_done  (byte_done),
    .sys_clk    (sys_clk),
    .sys_rst    (sys_rst),
    .byte_out   (byte_out),
    .byte_valid (byte_valid)
);

// File: tb/tb_sba_aligner.sv
`timescale 1ns/1ps
module tb_sba_aligner;
    localparam int         PB   = 3;
    localparam int         ML   = 2;
    localparam logic [7:0] PAT  = 8'h47;

    logic bit_clk = 1'b0, sys_clk = 1'b0;
    logic bit_rst = 1'b1, sys_rst = 1'b1;
    logic ser_in = 1'b0, resync = 1'b0;
    logic sync_found, byte_valid;
    logic [7:0] byte_out;

    always #7 bit_clk = ~bit_clk;
    always #2 sys_clk = ~sys_clk;

    sba_aligner #(.PERIOD_BYTES(PB), .MISS_LIMIT(ML), .SYNC_PAT(PAT)) dut (
        .bit_clk(bit_clk), .bit_rst(bit_rst), .ser_in(ser_in), .resync(resync),
        .sync_found(sync_found), .sys_clk(sys_clk), .sys_rst(sys_rst),
        .byte_out(byte_out), .byte_valid(byte_valid)
    );

    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference, bit domain
    logic [7:0] m_sr = 0;
    bit m_lock = 0;
    int m_cnt = 0, m_slot = 0, m_miss = 0;
    logic [7:0] exp_q[$];

    always @(posedge bit_clk) begin
        logic [7:0] nxt;
        if (bit_rst) begin
            m_sr = 0; m_lock = 0; m_cnt = 0; m_slot = 0; m_miss = 0;
        end else begin
            nxt = {m_sr[6:0], ser_in};
            if (resync) begin
                m_lock = 0; m_cnt = 0; m_slot = 0; m_miss = 0;
            end else if (!m_lock) begin
                if (nxt == PAT) begin
                    m_lock = 1; m_cnt = 0; m_slot = 0; m_miss = 0;
                end
            end else begin
                if (m_cnt == 7) begin
                    if (m_slot == PB) begin
                        m_slot = 0;
                        if (nxt == PAT) m_miss = 0;
                        else begin
                            m_miss++;
                            if (m_miss == ML) begin m_lock = 0; m_miss = 0; end
                        end
                    end else begin
                        exp_q.push_back(nxt);
                        m_slot++;
                    end
                end
                m_cnt = (m_cnt + 1) % 8;
            end
            m_sr = nxt;
        end
    end

    // per-cycle lock comparison
    always @(negedge bit_clk) begin
        if (!bit_rst && !finished)
            chk(sync_found == m_lock, "R5 lock vs model", sync_found, m_lock);
    end

    // system-domain delivery checks
    logic [7:0] last_del = 0;
    bit prev_valid = 0;
    int delivered = 0;
    logic [7:0] first_del = 0;
    always @(negedge sys_clk) begin
        if (sys_rst) begin
            last_del = 0; prev_valid = 0;
        end else if (!finished) begin
            if (byte_valid) begin
                chk(!prev_valid, "R7 pulse width", 1, 0);
                if (exp_q.size() == 0) chk(0, "R7 unexpected byte", byte_out, 0);
                else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(byte_out == e, "R7 byte value", byte_out, e);
                end
                if (delivered == 0) first_del = byte_out;
                delivered++;
                last_del = byte_out;
            end else begin
                chk(byte_out == last_del, "R8 held value", byte_out, last_del);
            end
            prev_valid = byte_valid;
        end
    end

    task automatic send_bit(input logic b, input logic rs = 1'b0);
        ser_in = b; resync = rs;
        @(negedge bit_clk);
        resync = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic send_zeros(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b0);
    endtask

    task automatic do_reset();
        bit_rst = 1'b1; sys_rst = 1'b1;
        repeat (5) @(negedge bit_clk);
        exp_q.delete();
        bit_rst = 1'b0; sys_rst = 1'b0;
        @(negedge bit_clk);
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge bit_clk);
        do_reset();
        chk(sync_found == 1'b0, "R1 sync_found after reset", sync_found, 0);
        chk(byte_valid == 1'b0, "R1 byte_valid after reset", byte_valid, 0);
        chk(byte_out == 8'h00, "R1 byte_out after reset", byte_out, 0);

        // R2: misaligned start, then sync byte MSB first
        send_zeros(5);
        for (int i = 7; i >= 1; i--) send_bit(PAT[i]);
        chk(sync_found == 1'b0, "R2 no lock before last bit", sync_found, 0);
        send_bit(PAT[0]);
        chk(sync_found == 1'b1, "R2 lock on pattern", sync_found, 1);

        // R3/R4: payload containing the pattern
        send_byte(8'hA5); send_byte(8'h3C); send_byte(PAT);
        chk(sync_found == 1'b1, "R4 still locked after payload pattern", sync_found, 1);
        send_byte(PAT);
        send_byte(8'h12); send_byte(PAT); send_byte(8'hE7);
        send_byte(PAT);
        repeat (20) @(negedge sys_clk);
        chk(delivered == 6, "R3 payload count", delivered, 6);
        chk(first_del == 8'hA5, "R3 first payload byte", first_del, 8'hA5);

        // R5: single miss keeps lock, good sync clears, two misses drop
        send_byte(8'h01); send_byte(8'h02); send_byte(8'h03);
        send_byte(8'h00);
        chk(sync_found == 1'b1, "R5 one miss keeps lock", sync_found, 1);
        send_byte(8'h04); send_byte(8'h05); send_byte(8'h06);
        send_byte(PAT);
        send_byte(8'h07); send_byte(8'h08); send_byte(8'h09);
        send_byte(8'h00);
        chk(sync_found == 1'b1, "R5 count cleared by good sync", sync_found, 1);
        send_byte(8'h0A); send_byte(8'h0B); send_byte(8'h0C);
        send_byte(8'hFF);
        chk(sync_found == 1'b0, "R5 miss limit drops lock", sync_found, 0);
        send_zeros(16);

        // R6: resync mid-frame, and resync beating a match
        send_byte(PAT);
        send_byte(8'h55); send_byte(8'hAA);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        send_bit(1'b1, 1'b1);
        chk(sync_found == 1'b0, "R6 resync drops lock", sync_found, 0);
        send_zeros(16);
        for (int i = 7; i >= 1; i--) send_bit(PAT[i]);
        send_bit(PAT[0], 1'b1);
        chk(sync_found == 1'b0, "R6 resync beats match", sync_found, 0);
        send_zeros(16);
        repeat (20) @(negedge sys_clk);

        // R1: reset in mid-stream, then recovery with varied payloads
        do_reset();
        chk(sync_found == 1'b0, "R1 sync_found after second reset", sync_found, 0);
        chk(byte_out == 8'h00, "R1 byte_out after second reset", byte_out, 0);
        send_zeros(3);
        send_byte(PAT);
        for (int f = 0; f < 6; f++) begin
            for (int k = 0; k < PB; k++) send_byte(8'($urandom));
            send_byte(PAT);
        end
        chk(sync_found == 1'b1, "R3 locked through varied frames", sync_found, 1);
        send_zeros(16);
        repeat (40) @(negedge sys_clk);
        chk(exp_q.size() == 0, "R7 no byte lost", exp_q.size(), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule